// File: doc/BRIEF.md
# UART Oversampling Baud Timer

This block produces the timing strobes that a 16550-class serial port needs for transmit and receive. A 16-bit clock prescaler emits a one-clock sample tick every `divisor` clocks. A bit sequencer counts these ticks into bit periods. It pulses a bit tick at the end of each period and a receive-sample strobe at a chosen tick inside the period. The oversampling ratio is either fixed (16 or 4 ticks per bit) or programmable from 1 to 256 ticks. In programmable mode the sample tick position is also set by software. The bit rate is then the clock rate divided by `divisor × ticks-per-bit`.

Software writes six byte-wide registers through a plain write port. A format register holds the line-format bits and a gate bit (bit 7). The two divisor bytes can only be written while the gate bit is 1. The remaining registers are the oversampling mode, the tick count field and the sample-point field. Serial shifting, FIFOs, interrupts and status logic belong to other blocks.

The sequencer is a three-state machine:
- `ST_IDLE` is the single cycle held after reset, with all counters frozen.
- `ST_PRE` is the part of a bit before the strobe has fired.
- `ST_POST` is the rest of the bit after the strobe.

Transitions:
- `ST_IDLE→ST_PRE` always happens on the first clock after reset.
- `ST_PRE→ST_POST` happens on the sample tick whose index equals the sample point.
- `ST_PRE→ST_PRE` and `ST_POST→ST_PRE` happen on the last tick of a bit.
- Any state except `ST_IDLE` returns to `ST_PRE` on a restarting register write.

Top module: `uart_baud_timer`

## Requirements
- R1: On reset all three outputs are low and the registers take these values: gate 0, divisor 0, mode 0, count field 0x0F, point field 0x07.
- R2: Register addresses are 0 format (bit 7 = gate), 1 divisor low byte, 2 divisor high byte, 3 mode (bits 1:0), 4 count field, 5 point field. A divisor write made while the gate is 0 is ignored and does not restart anything.
- R3: `sample_tick` pulses for one clock every D clocks, where D is the 16-bit divisor. A divisor of 0 acts as 1. After a restart, the first tick comes D clocks later (the D-th cycle counting from 1).
- R4: Mode 0 and mode 1 give 16 ticks per bit with the strobe on tick 7 (ticks counted from 0). The point field is ignored.
- R5: Mode 2 gives 4 ticks per bit with the strobe on tick 1.
- R6: Mode 3 gives count field + 1 ticks per bit (1 to 256) and fires the strobe on the tick equal to the point field. If the point field exceeds the count field, no strobe fires. At most one strobe fires per bit.
- R7: `bit_tick` pulses, together with `sample_tick`, on the last tick of each bit.
- R8: An accepted write to addresses 1, 2, 3 or 4 clears the prescaler and the tick index on that clock edge. Writes to addresses 0 and 5 leave the running timing undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| sample_tick | output | 1 | One pulse per oversampling tick |
| bit_tick | output | 1 | One pulse at the end of each bit period |
| rx_strobe | output | 1 | Receive-sample pulse inside each bit |

## Verification
The bench builds the block with its default parameters: 8-bit register bytes and therefore a 16-bit divisor and an 8-bit count field. These defaults put the full 256-tick programmable bit and a divisor of 256 (high byte only) within reach of short runs. The same runs also cover the single-tick bit, where every tick is both a bit end and a strobe. One run places the sample point past the last tick, so that no strobe may fire.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
    typedef enum logic [2:0] {
        A_FMT   = 3'd0,
        A_DIVLO = 3'd1,
        A_DIVHI = 3'd2,
        A_MODE  = 3'd3,
        A_CNT   = 3'd4,
        A_PNT   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        OS_X16     = 2'd0,
        OS_X16_ALT = 2'd1,
        OS_X4      = 2'd2,
        OS_PROG    = 2'd3
    } os_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2
    } seq_state_e;
endpackage

// File: rtl/uart_baud_regs.sv
module uart_baud_regs
    import uart_baud_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    localparam int DIV_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [1:0]        mode_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] pnt_q,
    output logic              restart
);
    logic gate_q;
    logic fmt_we, dlo_we, dhi_we, mode_we, cnt_we, pnt_we;

    always_comb begin
        fmt_we  = wr_en && (wr_addr == ADDR_W'(A_FMT));
        dlo_we  = wr_en && (wr_addr == ADDR_W'(A_DIVLO)) && gate_q;
        dhi_we  = wr_en && (wr_addr == ADDR_W'(A_DIVHI)) && gate_q;
        mode_we = wr_en && (wr_addr == ADDR_W'(A_MODE));
        cnt_we  = wr_en && (wr_addr == ADDR_W'(A_CNT));
        pnt_we  = wr_en && (wr_addr == ADDR_W'(A_PNT));
        restart = dlo_we || dhi_we || mode_we || cnt_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            div_q  <= '0;
            mode_q <= OS_X16;
            cnt_q  <= DATA_W'(15);
            pnt_q  <= DATA_W'(7);
        end else begin
            if (fmt_we)  gate_q <= wr_data[DATA_W-1];
            if (dlo_we)  div_q[DATA_W-1:0] <= wr_data;
            if (dhi_we)  div_q[DIV_W-1:DATA_W] <= wr_data;
            if (mode_we) mode_q <= wr_data[1:0];
            if (cnt_we)  cnt_q <= wr_data;
            if (pnt_we)  pnt_q <= wr_data;
        end
    end
endmodule

// File: rtl/uart_baud_prescale.sv
module uart_baud_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_q,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_last;

    always_comb begin
        div_last = (div_q == '0) ? '0 : div_q - DIV_W'(1);
        tick     = run && (cnt_q == div_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (run)
            cnt_q <= (cnt_q == div_last) ? '0 : cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/uart_baud_bitseq.sv
module uart_baud_bitseq
    import uart_baud_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             samp_tick,
    input  logic [1:0]       mode_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] pnt_q,
    output logic             run,
    output logic             bit_tick,
    output logic             rx_strobe
);
    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] last_idx, samp_idx;
    logic             at_last, at_point;

    always_comb begin
        unique case (os_mode_e'(mode_q))
            OS_X4: begin
                last_idx = CNT_W'(3);
                samp_idx = CNT_W'(1);
            end
            OS_PROG: begin
                last_idx = cnt_q;
                samp_idx = pnt_q;
            end
            default: begin
                last_idx = CNT_W'(15);
                samp_idx = CNT_W'(7);
            end
        endcase
        at_last  = samp_tick && (idx_q == last_idx);
        at_point = samp_tick && (idx_q == samp_idx);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_PRE;
            ST_PRE: begin
                if (restart || at_last) state_d = ST_PRE;
                else if (at_point)      state_d = ST_POST;
            end
            ST_POST: begin
                if (restart || at_last) state_d = ST_PRE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (restart || state_q == ST_IDLE)
                idx_q <= '0;
            else if (samp_tick)
                idx_q <= at_last ? '0 : idx_q + CNT_W'(1);
        end
    end

    always_comb begin
        run       = (state_q != ST_IDLE);
        bit_tick  = at_last;
        rx_strobe = (state_q == ST_PRE) && at_point;
    end
endmodule

// File: rtl/uart_baud_timer.sv
module uart_baud_timer #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              rx_strobe
);
    localparam int DIV_W = 2 * DATA_W;

    logic [DIV_W-1:0]  div_q;
    logic [1:0]        mode_q;
    logic [DATA_W-1:0] cnt_q, pnt_q;
    logic              restart, run;

    uart_baud_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_q(div_q), .mode_q(mode_q), .cnt_q(cnt_q),
        .pnt_q(pnt_q), .restart(restart)
    );

    uart_baud_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .div_q(div_q), .tick(sample_tick)
    );

    uart_baud_bitseq #(.CNT_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(restart), .samp_tick(sample_tick),
        .mode_q(mode_q), .cnt_q(cnt_q), .pnt_q(pnt_q), .run(run),
        .bit_tick(bit_tick), .rx_strobe(rx_strobe)
    );
endmodule

// File: rtl/uart_baud_timer_chk.sv
module uart_baud_timer_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                sample_tick,
    input logic                bit_tick,
    input logic                rx_strobe,
    input logic [2*DATA_W-1:0] div_q
);
    logic div_wr, seen_q;

    always_comb div_wr = wr_en && (wr_addr == ADDR_W'(1) || wr_addr == ADDR_W'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                seen_q <= 1'b0;
        else if (bit_tick || wr_en) seen_q <= 1'b0;
        else if (rx_strobe)        seen_q <= 1'b1;
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!sample_tick && !bit_tick && !rx_strobe);
        end
    end

    // R7
    bit_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    // R6
    strobe_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> sample_tick);

    // R6
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> !seen_q);

    // R2
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_wr |=> $stable(div_q));

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && div_q > (2*DATA_W)'(1) && !wr_en) |=> !sample_tick);
endmodule

bind uart_baud_timer uart_baud_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .rx_strobe(rx_strobe),
    .div_q(div_q)
);

// File: tb/uart_baud_timer_tb.sv
module uart_baud_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sample_tick, bit_tick, rx_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  s;
        logic  b;
        logic  r;
        string tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    uart_baud_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick),
        .rx_strobe(rx_strobe)
    );

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // restarting write, then queue n cycles of predicted outputs
    task automatic launch(input logic [2:0] a, input logic [7:0] d, input int div,
                          input int last, input int pt, input int n, input string tag);
        write_reg(a, d);
        for (int c = 0; c < n; c++) begin
            exp_t e;
            int   k, idx;
            e.s = ((c + 1) % div) == 0;
            k   = (c + 1) / div - 1;
            idx = (k < 0) ? 0 : k % (last + 1);
            e.b = e.s && (idx == last);
            e.r = e.s && (idx == pt);
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic check3(input string tag, input logic s, input logic b, input logic r,
                          input logic es, input logic eb, input logic er);
        checks++;
        if ({s, b, r} !== {es, eb, er}) begin
            errors++;
            $display("FAIL %s: got tick/bit/strobe=%b%b%b expected %b%b%b at %0t",
                     tag, s, b, r, es, eb, er, $time);
        end
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check3(e.tag, sample_tick, bit_tick, rx_strobe, e.s, e.b, e.r);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet while reset is held
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check3("R1", sample_tick, bit_tick, rx_strobe, 1'b0, 1'b0, 1'b0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: defaults divisor 0 (acts as 1), count 0x0F, point 0x07
        launch(3'd3, 8'd3, 1, 15, 7, 40, "R1");
        drain();

        // R5: mode 2 with divisor 3
        write_reg(3'd0, 8'h83);
        write_reg(3'd1, 8'd3);
        write_reg(3'd2, 8'd0);
        launch(3'd3, 8'd2, 3, 3, 1, 60, "R5");
        drain();

        // R4: mode 1 acts as 16x, point field ignored
        write_reg(3'd5, 8'd2);
        launch(3'd3, 8'd1, 3, 15, 7, 120, "R4");
        drain();

        // R2: divisor write with gate clear is ignored
        write_reg(3'd0, 8'h03);
        write_reg(3'd1, 8'd9);
        launch(3'd3, 8'd2, 3, 3, 1, 40, "R2");
        drain();

        // R6: programmable 5 ticks, strobe on tick 2, divisor 2
        write_reg(3'd0, 8'h80);
        write_reg(3'd1, 8'd2);
        write_reg(3'd4, 8'd4);
        write_reg(3'd5, 8'd2);
        launch(3'd3, 8'd3, 2, 4, 2, 40, "R6");
        drain();

        // R6: point beyond count gives no strobe
        write_reg(3'd5, 8'd9);
        launch(3'd4, 8'd4, 2, 4, 9, 40, "R6");
        drain();

        // R7: single-tick bit, every tick ends a bit
        write_reg(3'd5, 8'd0);
        launch(3'd4, 8'd0, 2, 0, 0, 20, "R7");
        drain();

        // R6: maximum 256 ticks per bit
        write_reg(3'd5, 8'd127);
        launch(3'd4, 8'd255, 2, 255, 127, 1100, "R6");
        drain();

        // R8: high divisor byte write restarts, divisor 256
        write_reg(3'd1, 8'd0);
        write_reg(3'd3, 8'd2);
        launch(3'd2, 8'd1, 256, 3, 1, 2100, "R8");
        repeat (600) @(negedge clk);
        // R3: restart mid-bit to divisor 0, which acts as 1
        q.delete();
        launch(3'd2, 8'd0, 1, 3, 1, 30, "R3");
        drain();

        // R8: writes to format and point registers do not disturb timing
        write_reg(3'd4, 8'd7);
        write_reg(3'd5, 8'd3);
        launch(3'd3, 8'd3, 1, 7, 3, 60, "R8");
        repeat (10) @(negedge clk);
        write_reg(3'd0, 8'h83);
        repeat (5) @(negedge clk);
        write_reg(3'd5, 8'd3);
        drain();

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule